// File: doc/BRIEF.md
# Character-String Instruction Sequencer

This block runs programs of 12-bit string instructions against a character memory of 6-bit characters (eight of them make up one 48-bit word). It holds a source pointer, a destination pointer, a program counter and one loop counter. There is no operand stack: a move instruction copies as many characters from the source pointer to the destination pointer as its count field gives. A loop-open and loop-close pair repeats the instructions between them without any separate counter or branch instruction. A leave instruction hands control back to the surrounding word-oriented machine.

A host loads the start address and the two pointer bases and pulses `start`. The block fetches instructions by presenting `pc` and reading `instr` in the same cycle. It reads characters through a port with combinational read data and writes through a separate strobe. While a program is running, `char_mode` stays high. `mode_exit` pulses when the program leaves.

The controller has three states. IDLE goes to DISPATCH on `start`, which loads the program counter and both pointers. DISPATCH decodes the instruction at `pc`. A move with a nonzero count goes to MOVE. A leave goes back to IDLE. Every other instruction stays in DISPATCH with a new `pc`. MOVE transfers one character per cycle and returns to DISPATCH after the last one.

Top module: `cm_char_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the block is idle: `char_mode`, `rd_en`, `wr_en` and `mode_exit` are low, and `pc`, `rd_addr` and `wr_addr` are zero.
- R2: When `start` is high in the idle state, the next edge loads `pc` with `start_pc`, `rd_addr` with `src_base` and `wr_addr` with `dst_base`, and raises `char_mode`.
- R3: An instruction has a count in bits [11:6] and an opcode in bits [5:0]. Opcode 0x01 is move, 0x02 is loop-open, 0x03 is loop-close and 0x3F is leave. Any other opcode is a no-op: it takes one cycle, has no strobes, and sets `pc` to `pc`+1.
- R4: A move with count N>0 takes one dispatch cycle and then N cycles. In each of those N cycles, `rd_en` and `wr_en` are high and `wr_data` equals the `rd_data` of that same cycle. Afterwards `pc` becomes `pc`+1.
- R5: A move with count 0 takes one cycle, raises no strobe, and sets `pc` to `pc`+1.
- R6: The source and destination addresses each rise by one for every character moved, wrapping modulo 2^ADDR_W. They hold their values at all other times and carry over into later instructions.
- R7: Loop-open stores its count in the loop counter and stores its own address. It then sets `pc` to `pc`+1 in one cycle.
- R8: If the loop counter is above 1, loop-close decrements it and jumps to the stored address plus 1. Otherwise it sets the counter to 0 and falls through to `pc`+1. As a result, a count of N runs the loop body N times, and a count of 0 or 1 runs it once.
- R9: Leave holds `mode_exit` high for the cycle in which it is at `pc`. On the next edge, `char_mode` drops and `pc` holds the address of the leave instruction.
- R10: `start` is ignored while `char_mode` is high.
- R11: `rd_en` and `wr_en` are only ever high during the character cycles of a move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch a program when idle |
| start_pc | input | PC_W | Address of the first instruction |
| src_base | input | ADDR_W | Initial source character address |
| dst_base | input | ADDR_W | Initial destination character address |
| pc | output | PC_W | Instruction address being fetched |
| instr | input | 12 | Instruction at `pc`, same cycle |
| rd_en | output | 1 | Character read strobe |
| rd_addr | output | ADDR_W | Source character address |
| rd_data | input | 6 | Character at `rd_addr`, same cycle |
| wr_en | output | 1 | Character write strobe |
| wr_addr | output | ADDR_W | Destination character address |
| wr_data | output | 6 | Character to write |
| char_mode | output | 1 | High while a program runs |
| mode_exit | output | 1 | One-cycle pulse on leave |

## Verification
The properties assume that `instr` and `rd_data` follow `pc` and `rd_addr` combinationally within the same cycle, so a character read in a move cycle can be written in that cycle. The bench meets this by driving both inputs from arrays through continuous assignments. It changes `start` and the base inputs only just after a rising edge. The pointer-stepping property also assumes that a move never stops partway through. The stimulus therefore always lets a program run until its leave instruction, and includes a start pulse in the middle of a run to show that it is ignored.

// File: rtl/cm_pkg.sv
package cm_pkg;
    localparam int REP_W   = 6;
    localparam int OP_W    = 6;
    localparam int CHAR_W  = 6;
    localparam int INSTR_W = REP_W + OP_W;

    localparam logic [OP_W-1:0] OP_MOVE  = OP_W'('h01);
    localparam logic [OP_W-1:0] OP_OPEN  = OP_W'('h02);
    localparam logic [OP_W-1:0] OP_CLOSE = OP_W'('h03);
    localparam logic [OP_W-1:0] OP_LEAVE = OP_W'('h3F);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DISPATCH,
        ST_MOVE
    } seq_state_t;

    typedef enum logic [2:0] {
        K_NOP,
        K_MOVE,
        K_MOVE_EMPTY,
        K_OPEN,
        K_CLOSE,
        K_LEAVE
    } instr_kind_t;

    typedef struct packed {
        instr_kind_t        kind;
        logic [REP_W-1:0]   rep;
    } decoded_t;
endpackage

// File: rtl/cm_decode.sv
module cm_decode
    import cm_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output decoded_t           dec
);
    logic [OP_W-1:0]  opcode;
    logic [REP_W-1:0] count;

    assign opcode = instr[OP_W-1:0];
    assign count  = instr[INSTR_W-1:OP_W];

    always_comb begin
        dec.rep = count;
        unique case (opcode)
            OP_MOVE:  dec.kind = (count == '0) ? K_MOVE_EMPTY : K_MOVE;
            OP_OPEN:  dec.kind = K_OPEN;
            OP_CLOSE: dec.kind = K_CLOSE;
            OP_LEAVE: dec.kind = K_LEAVE;
            default:  dec.kind = K_NOP;
        endcase
    end
endmodule

// File: rtl/cm_loop_ctl.sv
module cm_loop_ctl
    import cm_pkg::*;
#(
    parameter int PC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_loop,
    input  logic             close_loop,
    input  logic [REP_W-1:0] open_count,
    input  logic [PC_W-1:0]  open_pc,
    output logic             go_back,
    output logic [PC_W-1:0]  back_pc
);
    logic [REP_W-1:0] iter_q;
    logic [PC_W-1:0]  head_q;

    assign go_back = iter_q > REP_W'(1);
    assign back_pc = head_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iter_q <= '0;
            head_q <= '0;
        end else if (open_loop) begin
            iter_q <= open_count;
            head_q <= open_pc;
        end else if (close_loop) begin
            iter_q <= go_back ? iter_q - 1'b1 : '0;
        end
    end
endmodule

// File: rtl/cm_ptr_unit.sv
module cm_ptr_unit
    import cm_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_base,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic              load_len,
    input  logic [REP_W-1:0]  len,
    input  logic              step,
    output logic [ADDR_W-1:0] src_ptr,
    output logic [ADDR_W-1:0] dst_ptr,
    output logic              last_char
);
    logic [REP_W-1:0] left_q;

    assign last_char = left_q == REP_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_ptr <= '0;
            dst_ptr <= '0;
        end else if (load_base) begin
            src_ptr <= src_base;
            dst_ptr <= dst_base;
        end else if (step) begin
            src_ptr <= src_ptr + 1'b1;
            dst_ptr <= dst_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            left_q <= '0;
        else if (load_len)
            left_q <= len;
        else if (step)
            left_q <= left_q - 1'b1;
    end
endmodule

// File: rtl/cm_char_seq.sv
module cm_char_seq
    import cm_pkg::*;
#(
    parameter int PC_W   = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PC_W-1:0]   start_pc,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    output logic [PC_W-1:0]   pc,
    input  logic [11:0]       instr,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [5:0]        rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [5:0]        wr_data,
    output logic              char_mode,
    output logic              mode_exit
);
    seq_state_t       state_q, state_d;
    logic [PC_W-1:0]  pc_q, pc_d;
    decoded_t         dec;
    logic             launch, do_open, do_close, move_begin, move_step;
    logic             go_back, last_char;
    logic [PC_W-1:0]  back_pc;

    cm_decode u_decode (
        .instr (instr),
        .dec   (dec)
    );

    cm_loop_ctl #(.PC_W(PC_W)) u_loop (
        .clk        (clk),
        .rst_n      (rst_n),
        .open_loop  (do_open),
        .close_loop (do_close),
        .open_count (dec.rep),
        .open_pc    (pc_q),
        .go_back    (go_back),
        .back_pc    (back_pc)
    );

    cm_ptr_unit #(.ADDR_W(ADDR_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_base (launch),
        .src_base  (src_base),
        .dst_base  (dst_base),
        .load_len  (move_begin),
        .len       (dec.rep),
        .step      (move_step),
        .src_ptr   (rd_addr),
        .dst_ptr   (wr_addr),
        .last_char (last_char)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pc_q    <= '0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
        end
    end

    // Transitions
    always_comb begin
        state_d    = state_q;
        pc_d       = pc_q;
        launch     = 1'b0;
        do_open    = 1'b0;
        do_close   = 1'b0;
        move_begin = 1'b0;
        move_step  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_DISPATCH;
                    pc_d    = start_pc;
                    launch  = 1'b1;
                end
            end
            ST_DISPATCH: begin
                unique case (dec.kind)
                    K_MOVE: begin
                        state_d    = ST_MOVE;
                        move_begin = 1'b1;
                    end
                    K_OPEN: begin
                        do_open = 1'b1;
                        pc_d    = pc_q + 1'b1;
                    end
                    K_CLOSE: begin
                        do_close = 1'b1;
                        pc_d     = go_back ? back_pc : pc_q + 1'b1;
                    end
                    K_LEAVE: state_d = ST_IDLE;
                    default: pc_d = pc_q + 1'b1;
                endcase
            end
            ST_MOVE: begin
                move_step = 1'b1;
                if (last_char) begin
                    state_d = ST_DISPATCH;
                    pc_d    = pc_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        pc        = pc_q;
        char_mode = state_q != ST_IDLE;
        rd_en     = state_q == ST_MOVE;
        wr_en     = state_q == ST_MOVE;
        wr_data   = rd_data;
        mode_exit = (state_q == ST_DISPATCH) && (dec.kind == K_LEAVE);
    end
endmodule

// File: rtl/cm_char_seq_chk.sv
module cm_char_seq_chk #(
    parameter int PC_W   = 8,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              rd_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              char_mode,
    input logic              mode_exit
);
    // R2
    start_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !char_mode) |=> char_mode);

    // R9
    exit_leaves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_exit |=> !char_mode);

    // R9
    exit_in_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_exit |-> char_mode);

    // R11
    strobe_in_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en || wr_en) |-> char_mode);

    // R6
    dst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_addr == ADDR_W'($past(wr_addr) + 1'b1)));

    // R6
    src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(char_mode) && !$past(rd_en)) |-> $stable(rd_addr));
endmodule

bind cm_char_seq cm_char_seq_chk #(.PC_W(PC_W), .ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_cm_char_seq.sv
module test_cm_char_seq;
    localparam int PC_W   = 8;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [PC_W-1:0]   start_pc = '0;
    logic [ADDR_W-1:0] src_base = '0;
    logic [ADDR_W-1:0] dst_base = '0;
    logic [PC_W-1:0]   pc;
    logic [11:0]       instr;
    logic              rd_en, wr_en, char_mode, mode_exit;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [5:0]        rd_data, wr_data;

    logic [11:0] imem [256];
    logic [5:0]  mem  [256];
    logic [5:0]  m_mem [256];

    int checks = 0;
    int errors = 0;
    int m_st, m_pc, m_src, m_dst, m_rem, m_cnt, m_ret;

    always #4 clk = ~clk;

    cm_char_seq #(.PC_W(PC_W), .ADDR_W(ADDR_W)) i_cm_char_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_pc(start_pc),
        .src_base(src_base), .dst_base(dst_base), .pc(pc), .instr(instr),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .char_mode(char_mode), .mode_exit(mode_exit)
    );

    assign instr   = imem[pc];
    assign rd_data = mem[rd_addr];

    always @(posedge clk) if (wr_en) mem[wr_addr] <= wr_data;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [11:0] ins(int rep, int op);
        return {rep[5:0], op[5:0]};
    endfunction

    // Reference model, compared on every falling edge, then stepped
    always @(negedge clk) begin
        int op, rep;
        string tag;
        if (!rst_n) begin
            m_st = 0; m_pc = 0; m_src = 0; m_dst = 0;
            m_rem = 0; m_cnt = 0; m_ret = 0;
        end
        op  = int'(imem[m_pc][5:0]);
        rep = int'(imem[m_pc][11:6]);
        if (!rst_n) tag = "R1";
        else if (m_st == 2) tag = "R4";
        else if (m_st == 0) tag = "R2";
        else if (op == 1) tag = (rep == 0) ? "R5" : "R4";
        else if (op == 2) tag = "R7";
        else if (op == 3) tag = "R8";
        else if (op == 63) tag = "R9";
        else tag = "R3";
        chk((start && m_st != 0) ? "R10" : tag, "char_mode", int'(char_mode), int'(m_st != 0));
        chk(tag, "pc", int'(pc), m_pc);
        chk("R11", "rd_en", int'(rd_en), int'(m_st == 2));
        chk("R11", "wr_en", int'(wr_en), int'(m_st == 2));
        chk("R6", "rd_addr", int'(rd_addr), m_src);
        chk("R6", "wr_addr", int'(wr_addr), m_dst);
        chk("R9", "mode_exit", int'(mode_exit), int'(m_st == 1 && op == 63));
        if (m_st == 2) chk("R4", "wr_data", int'(wr_data), int'(m_mem[m_src]));
        if (rst_n) begin
            case (m_st)
                0: if (start) begin
                    m_st = 1; m_pc = int'(start_pc);
                    m_src = int'(src_base); m_dst = int'(dst_base);
                end
                1: begin
                    if (op == 1) begin
                        if (rep == 0) m_pc = (m_pc + 1) & 255;
                        else begin m_rem = rep; m_st = 2; end
                    end else if (op == 2) begin
                        m_cnt = rep; m_ret = m_pc; m_pc = (m_pc + 1) & 255;
                    end else if (op == 3) begin
                        if (m_cnt > 1) begin m_cnt = m_cnt - 1; m_pc = (m_ret + 1) & 255; end
                        else begin m_cnt = 0; m_pc = (m_pc + 1) & 255; end
                    end else if (op == 63) m_st = 0;
                    else m_pc = (m_pc + 1) & 255;
                end
                default: begin
                    m_mem[m_dst] = m_mem[m_src];
                    m_src = (m_src + 1) & 255;
                    m_dst = (m_dst + 1) & 255;
                    m_rem = m_rem - 1;
                    if (m_rem == 0) begin m_st = 1; m_pc = (m_pc + 1) & 255; end
                end
            endcase
        end
    end

    task automatic run(int p, int s, int d, int poke_after);
        @(posedge clk); #1;
        start = 1'b1; start_pc = PC_W'(p); src_base = ADDR_W'(s); dst_base = ADDR_W'(d);
        @(posedge clk); #1;
        start = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            if (i == poke_after) begin
                // R10: start pulse while running
                start = 1'b1; start_pc = 8'd200; src_base = 8'd7; dst_base = 8'd9;
            end
            if (i == poke_after + 2) start = 1'b0;
            @(posedge clk); #1;
            if (!char_mode) break;
        end
        start = 1'b0;
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int bad;
        for (int i = 0; i < 256; i++) begin
            imem[i]  = 12'h000;
            mem[i]   = 6'((i * 7 + 3) & 63);
            m_mem[i] = 6'((i * 7 + 3) & 63);
        end
        // Program A: loop of 3 around a 2-char move, empty move, no-op, leave
        imem[0] = ins(3, 2);  imem[1] = ins(2, 1);  imem[2] = ins(0, 3);
        imem[3] = ins(0, 1);  imem[4] = ins(5, 21); imem[5] = ins(0, 63);
        // Program B: close with zero count, open 0, single-pass body, longer move
        imem[16] = ins(0, 3); imem[17] = ins(0, 2); imem[18] = ins(1, 1);
        imem[19] = ins(0, 3); imem[20] = ins(7, 1); imem[21] = ins(0, 63);
        // Program C: maximum move with source wrap, count-1 loop
        imem[32] = ins(63, 1); imem[33] = ins(1, 2); imem[34] = ins(0, 16);
        imem[35] = ins(0, 3);  imem[36] = ins(0, 63);
        // Program D: overlapping copy inside a loop of 4
        imem[48] = ins(4, 2);  imem[49] = ins(3, 1); imem[50] = ins(9, 3);
        imem[51] = ins(0, 63);

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        run(0, 0, 100, 4);
        run(16, 40, 120, -1);
        run(32, 250, 180, 10);
        run(48, 60, 62, -1);
        run(0, 10, 140, -1);

        bad = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== m_mem[i]) bad++;
        chk("R4", "memory mismatches", bad, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule